// File: doc/BRIEF.md
# Configurable serial frame transmitter

This block turns one parallel character into a serial frame on a single line. The frame is a start bit, five to nine data bits, an optional parity bit and one or two stop bits. The format is chosen at run time from thirty legal combinations. A producer offers a word of up to nine bits with a valid/ready handshake. The block accepts a word only while it is idle. The word and the format inputs are latched in one holding register when the handshake completes.

The frame moves forward by one bit on each shift-enable pulse. That pulse comes from an external baud generator in asynchronous use. In clocked use it is the data-change strobe of the serial clock. Between pulses the line holds its current bit. Between frames the line idles high.

Top module: `ser_frame_tx`

## Requirements
- R1: After reset and between frames, `tx_o` is 1, `ready_o` is 1 and `busy_o` is 0. Shift-enable pulses while idle leave `tx_o` at 1.
- R2: When `valid_i` and `ready_o` are both high at a clock edge, the word is accepted. From the next cycle `busy_o` is 1, `ready_o` is 0 and `tx_o` drives the start bit (0). The start bit holds until the first shift-enable pulse.
- R3: The data bits follow the start bit, least significant bit first. The count is set by `len_sel_i`: codes 0,1,2,3,4 give 5,6,7,8,9 bits, and codes 5 to 7 give 9 bits.
- R4: `par_sel_i` selects parity: 0 = none, 1 = even, 2 = odd, 3 = none. When parity is on, one parity bit follows the last data bit. With even parity the count of ones across the active data bits and the parity bit is even. With odd parity that count is odd. Inactive data bits do not affect the parity.
- R5: After the data bits (and the parity bit, if any), the line sends stop bits at 1. `stop2_i` = 0 gives one stop bit and `stop2_i` = 1 gives two.
- R6: Each `shift_en_i` pulse during a frame advances exactly one bit. In cycles without a pulse, `tx_o` and `busy_o` do not change.
- R7: The data, length, parity and stop settings are taken at acceptance. Changes to these inputs during a frame, and `valid_i` asserted while busy, do not alter the frame in progress.
- R8: The pulse that ends the last stop bit returns the block to idle on the next cycle. A new word can be accepted in that same idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | 9 | Character to send, LSB first |
| valid_i | input | 1 | Character offered |
| ready_o | output | 1 | Transmitter idle, can accept |
| len_sel_i | input | 3 | Data length code |
| par_sel_i | input | 2 | Parity mode code |
| stop2_i | input | 1 | Two stop bits when 1 |
| shift_en_i | input | 1 | Advance one bit |
| tx_o | output | 1 | Serial line, idles high |
| busy_o | output | 1 | Frame in progress |

## Verification
Some properties are checked on every cycle:
- the idle line stays high;
- each frame starts with a low start bit;
- the line and the busy flag do not change without a shift pulse;
- the latched format stays fixed during a frame;
- the data bit index stays within the latched length.

Only the bench's scenarios show the rest:
- the full bit order of a frame;
- the parity value for each mode;
- the number of stop bits;
- that inputs changed mid-frame leave the frame unchanged.

The bench covers all thirty formats with edge data patterns, plus random frames with random pulse gaps.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  localparam logic [1:0] PAR_EVEN = 2'd1;
  localparam logic [1:0] PAR_ODD  = 2'd2;
endpackage

// File: rtl/ser_tx_fmt.sv
module ser_tx_fmt #(
  parameter int DATA_W  = 9,
  parameter int MIN_LEN = 5,
  localparam int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [2:0]        len_sel_i,
  input  logic [1:0]        par_sel_i,
  input  logic              stop2_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CNT_W-1:0]  len_o,
  output logic              par_en_o,
  output logic              par_bit_o,
  output logic              stop2_o
);
  import ser_tx_pkg::*;

  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  len_q, len_d;
  logic [1:0]        par_q;
  logic              stop2_q;
  logic [DATA_W-1:0] mask;

  always_comb begin
    if (int'(len_sel_i) + MIN_LEN >= DATA_W) len_d = CNT_W'(DATA_W);
    else                                     len_d = CNT_W'(int'(len_sel_i) + MIN_LEN);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      len_q   <= CNT_W'(DATA_W);
      par_q   <= '0;
      stop2_q <= 1'b0;
    end else if (load_i) begin
      data_q  <= data_i;
      len_q   <= len_d;
      par_q   <= par_sel_i;
      stop2_q <= stop2_i;
    end
  end

  // parity only over active bits
  always_comb begin
    for (int i = 0; i < DATA_W; i++) mask[i] = (i < int'(len_q));
  end

  assign data_o    = data_q;
  assign len_o     = len_q;
  assign par_en_o  = (par_q == PAR_EVEN) || (par_q == PAR_ODD);
  assign par_bit_o = (^(data_q & mask)) ^ (par_q == PAR_ODD);
  assign stop2_o   = stop2_q;

  a_r7_fmt_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !load_i |=> $stable(data_q) && $stable(len_q) && $stable(par_q) && $stable(stop2_q));
endmodule

// File: rtl/ser_tx_seq.sv
module ser_tx_seq #(
  parameter int DATA_W = 9,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              shift_en_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic              par_en_i,
  input  logic              par_bit_i,
  input  logic              stop2_i,
  output logic              tx_o,
  output logic              busy_o
);
  import ser_tx_pkg::*;

  tx_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) begin state_d = ST_START; cnt_d = '0; end
      ST_START: if (shift_en_i) begin state_d = ST_DATA; cnt_d = '0; end
      ST_DATA:  if (shift_en_i) begin
        if (cnt_q == len_i - 1'b1) begin
          state_d = par_en_i ? ST_PAR : ST_STOP;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PAR:   if (shift_en_i) begin state_d = ST_STOP; cnt_d = '0; end
      ST_STOP:  if (shift_en_i) begin
        if (stop2_i && cnt_q == '0) cnt_d = CNT_W'(1);
        else                        state_d = ST_IDLE;
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: tx_o = 1'b0;
      ST_DATA:  tx_o = data_i[cnt_q];
      ST_PAR:   tx_o = par_bit_i;
      default:  tx_o = 1'b1;
    endcase
  end

  assign busy_o = (state_q != ST_IDLE);

  a_r1_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o);
  a_r2_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !tx_o);
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !shift_en_i |=> busy_o && $stable(tx_o));
  a_r3_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DATA |-> cnt_q < len_i);
endmodule

// File: rtl/ser_frame_tx.sv
module ser_frame_tx #(
  parameter int DATA_W  = 9,
  parameter int MIN_LEN = 5,
  localparam int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [2:0]        len_sel_i,
  input  logic [1:0]        par_sel_i,
  input  logic              stop2_i,
  input  logic              shift_en_i,
  output logic              tx_o,
  output logic              busy_o
);
  logic              accept;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  len_q;
  logic              par_en, par_bit, stop2_q;

  assign ready_o = !busy_o;
  assign accept  = valid_i && ready_o;

  ser_tx_fmt #(.DATA_W(DATA_W), .MIN_LEN(MIN_LEN)) u_fmt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .busy_i    (busy_o),
    .data_i    (data_i),
    .len_sel_i (len_sel_i),
    .par_sel_i (par_sel_i),
    .stop2_i   (stop2_i),
    .data_o    (data_q),
    .len_o     (len_q),
    .par_en_o  (par_en),
    .par_bit_o (par_bit),
    .stop2_o   (stop2_q)
  );

  ser_tx_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept),
    .shift_en_i (shift_en_i),
    .data_i     (data_q),
    .len_i      (len_q),
    .par_en_i   (par_en),
    .par_bit_i  (par_bit),
    .stop2_i    (stop2_q),
    .tx_o       (tx_o),
    .busy_o     (busy_o)
  );

  a_r2_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> busy_o && !ready_o);
endmodule

// File: tb/tb_ser_frame_tx.sv
module tb_ser_frame_tx;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [8:0] data_i = '0;
  logic       valid_i = 1'b0;
  logic       ready_o;
  logic [2:0] len_sel_i = '0;
  logic [1:0] par_sel_i = '0;
  logic       stop2_i = 1'b0;
  logic       shift_en_i = 1'b0;
  logic       tx_o, busy_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ser_frame_tx dut (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .valid_i(valid_i),
    .ready_o(ready_o), .len_sel_i(len_sel_i), .par_sel_i(par_sel_i),
    .stop2_i(stop2_i), .shift_en_i(shift_en_i), .tx_o(tx_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // expected frame: returns bit count, bits in fb[0..n-1]
  function automatic int build(input logic [8:0] d, input logic [2:0] lc,
                               input logic [1:0] pc, input bit s2, output bit fb[16]);
    int n = 0;
    int len = (lc > 4) ? 9 : int'(lc) + 5;
    bit p = 0;
    fb[n++] = 0;
    for (int i = 0; i < len; i++) begin fb[n++] = d[i]; p ^= d[i]; end
    if (pc == 1) fb[n++] = p;
    else if (pc == 2) fb[n++] = ~p;
    fb[n++] = 1;
    if (s2) fb[n++] = 1;
    return n;
  endfunction

  function automatic string req_of(input int k, input int n, input logic [2:0] lc,
                                   input logic [1:0] pc);
    int len = (lc > 4) ? 9 : int'(lc) + 5;
    if (k == 0) return "R2";
    if (k <= len) return "R3";
    if ((pc == 1 || pc == 2) && k == len + 1) return "R4";
    return (k >= n) ? "R8" : "R5";
  endfunction

  task automatic run_frame(input logic [8:0] d, input logic [2:0] lc,
                           input logic [1:0] pc, input bit s2, input bit noisy);
    bit fb[16];
    int n;
    n = build(d, lc, pc, s2, fb);
    @(negedge clk);
    chk(ready_o && !busy_o && tx_o, "R1", {ready_o, busy_o, tx_o}, 3'b101);
    data_i = d; len_sel_i = lc; par_sel_i = pc; stop2_i = s2; valid_i = 1;
    @(negedge clk);
    valid_i = 0;
    chk(busy_o && !ready_o, "R2", {busy_o, ready_o}, 2'b10);
    for (int k = 0; k < n; k++) begin
      int gap = noisy ? int'($urandom_range(0, 2)) : 0;
      for (int g = 0; g < gap; g++) begin
        if (noisy) begin
          // R7: mid-frame input churn, valid while busy
          data_i = 9'($urandom); len_sel_i = 3'($urandom); par_sel_i = 2'($urandom);
          stop2_i = 1'($urandom); valid_i = 1'($urandom);
        end
        @(negedge clk);
        chk(tx_o == fb[k] && busy_o, "R6", tx_o, fb[k]);
      end
      chk(tx_o == fb[k], (noisy && k > 0) ? "R7" : req_of(k, n, lc, pc), tx_o, fb[k]);
      valid_i = 0;
      shift_en_i = 1;
      @(negedge clk);
      shift_en_i = 0;
    end
    chk(!busy_o && ready_o && tx_o, "R8", {busy_o, ready_o, tx_o}, 3'b011);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++; total++;
        $display("FAIL watchdog act=%0d exp=0", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    chk(tx_o && ready_o && !busy_o, "R1", {tx_o, ready_o, busy_o}, 3'b110);
    rst_ni = 1;
    @(negedge clk);
    shift_en_i = 1;
    @(negedge clk);
    shift_en_i = 0;
    chk(tx_o && !busy_o, "R1", {tx_o, busy_o}, 2'b10);
    // start bit holds without pulses
    data_i = 9'h0FF; len_sel_i = 3; par_sel_i = 0; stop2_i = 0; valid_i = 1;
    @(negedge clk);
    valid_i = 0;
    repeat (4) begin
      @(negedge clk);
      chk(!tx_o && busy_o, "R2", tx_o, 0);
    end
    for (int k = 0; k < 10; k++) begin
      shift_en_i = 1; @(negedge clk); shift_en_i = 0;
    end
    chk(!busy_o && tx_o, "R8", busy_o, 0);
    // all thirty formats plus out-of-range length codes, edge patterns
    for (int lc = 0; lc < 8; lc++)
      for (int pc = 0; pc < 4; pc++)
        for (int s = 0; s < 2; s++) begin
          run_frame(9'h1FF, 3'(lc), 2'(pc), s[0], 0);
          run_frame(9'h000, 3'(lc), 2'(pc), s[0], 0);
          run_frame(9'h155, 3'(lc), 2'(pc), s[0], 0);
        end
    // R4: inactive high bits must not change parity
    run_frame(9'h1E0, 3'd0, 2'd1, 0, 0);
    run_frame(9'h100, 3'd3, 2'd2, 1, 0);
    for (int i = 0; i < 300; i++)
      run_frame(9'($urandom), 3'($urandom), 2'($urandom), 1'($urandom), 1);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule